// File: doc/BRIEF.md
# Programmable three-by-three pixel colour converter

This block turns each incoming pixel of three 8-bit components into a new three-component pixel. Each output channel is a weighted sum of all three input channels plus a per-channel constant, scaled by a power of two. The result is rounded to the nearest integer and clamped to a byte. The clamp can optionally be narrowed to the video range. With suitable coefficients the same datapath converts RGB to YCbCr, YCbCr to RGB, or passes RGB through unchanged.

Software loads the parameter set as six 32-bit words through a plain write port. The words land in a staging copy. A frame-start strobe moves the staging copy into the active copy, so a parameter update never takes effect in the middle of a frame. Pixels enter and leave on a valid/ready stream. The pipeline has a fixed depth, and every stage freezes together while the consumer is not ready.

Top module: `pix_matrix_conv`

## Requirements
- R1: Coefficient k[i][j] is a signed 9-bit integer in units of 1/256, where i is the output channel and j is the input channel. Word 0 carries k00 at [26:18], k11 at [17:9] and k22 at [8:0]. Word 2 carries k01 at [26:18], k10 at [17:9] and k20 at [8:0]. Word 4 carries k02 at [26:18], k12 at [17:9] and k21 at [8:0].
- R2: Offset n is a signed 13-bit value in units of 1/4. Its low five bits sit at [31:27] of word 0, 2 or 4 for n = 0, 1 or 2, and its high eight bits sit at [7:0] of word 1, 3 or 5. Word 1 also carries the scale code at [9:8] and the video-range flag at bit 10.
- R3: Pixels are packed with channel 0 at [7:0], channel 1 at [15:8] and channel 2 at [23:16]. Each output is floor(S*F/256 + off/4 + 1/2), where S is the sum over j of k[i][j]*in[j] and F is the scale factor. The result is then clamped.
- R4: Scale codes 0, 1, 2 and 3 give F = 1/2, 1, 2 and 4.
- R5: With the video-range flag clear, every output channel clamps to 0..255.
- R6: With the video-range flag set, channel 0 clamps to 16..235 and channels 1 and 2 clamp to 16..240.
- R7: Writes to words 0..5 change only the staging copy. The active copy takes the staging contents on a frame_start cycle, and pixels use only the active copy.
- R8: A pixel accepted in cycle n appears on out_pix with out_valid high in cycle n+3, and not earlier. Back-to-back pixels come out in order at one per cycle.
- R9: While out_ready is low, in_ready is low, and out_valid and out_pix hold their values. In-flight pixels resume their progress when out_ready rises.
- R10: After reset, out_valid is low and the active parameters are all zero, so every pixel converts to 0x000000 until the first frame_start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Parameter word write strobe |
| cfg_addr | input | 3 | Parameter word index, 0..5 |
| cfg_wdata | input | 32 | Parameter word value |
| frame_start | input | 1 | Copies staged parameters to the active set |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted when high with in_valid |
| in_pix | input | 24 | Input pixel, three 8-bit channels |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Consumer ready |
| out_pix | output | 24 | Converted pixel |

## Verification
An identity matrix is used to check that the coefficients land on the correct matrix positions. A channel-swap matrix then separates the off-diagonal fields from the diagonal ones. Single-coefficient patterns at every scale code isolate the scale factor, and inputs of 127 and 128 against a coefficient of 1/256 show whether rounding is to nearest. Offsets alone, with and without the video-range flag, drive each channel past both clamp bounds. A realistic RGB-to-YCbCr set compares mixed-sign sums against a floating-point model. Staged-but-unstrobed writes, back-to-back streams and a frozen consumer separate the shadow, ordering and stall behaviour.

// File: rtl/pix_matrix_conv.sv
module pix_matrix_conv #(
  parameter int CW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [2:0]      cfg_addr,
  input  logic [31:0]     cfg_wdata,
  input  logic            frame_start,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [3*CW-1:0] in_pix,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [3*CW-1:0] out_pix
);
  localparam int KW = 9;
  localparam int OW = 13;
  localparam int PW = KW + CW + 1;
  localparam int AW = 26;
  localparam int RW = AW - 9;

  logic [31:0] sw0, sw2, sw4, aw0, aw2, aw4;
  logic [10:0] sw1, aw1;
  logic [7:0]  sw3, sw5, aw3, aw5;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sw0 <= '0; sw1 <= '0; sw2 <= '0; sw3 <= '0; sw4 <= '0; sw5 <= '0;
      aw0 <= '0; aw1 <= '0; aw2 <= '0; aw3 <= '0; aw4 <= '0; aw5 <= '0;
    end else begin
      if (cfg_we) begin
        case (cfg_addr)
          3'd0: sw0 <= cfg_wdata;
          3'd1: sw1 <= cfg_wdata[10:0];
          3'd2: sw2 <= cfg_wdata;
          3'd3: sw3 <= cfg_wdata[7:0];
          3'd4: sw4 <= cfg_wdata;
          3'd5: sw5 <= cfg_wdata[7:0];
          default: ;
        endcase
      end
      if (frame_start) begin
        aw0 <= sw0; aw1 <= sw1; aw2 <= sw2;
        aw3 <= sw3; aw4 <= sw4; aw5 <= sw5;
      end
    end
  end

  logic signed [KW-1:0] k [3][3];
  logic signed [OW-1:0] off [3];
  logic [1:0] scl;
  logic       vid;

  always_comb begin
    k[0][0] = aw0[26:18]; k[1][1] = aw0[17:9]; k[2][2] = aw0[8:0];
    k[0][1] = aw2[26:18]; k[1][0] = aw2[17:9]; k[2][0] = aw2[8:0];
    k[0][2] = aw4[26:18]; k[1][2] = aw4[17:9]; k[2][1] = aw4[8:0];
    off[0] = {aw1[7:0], aw0[31:27]};
    off[1] = {aw3, aw2[31:27]};
    off[2] = {aw5, aw4[31:27]};
    scl = aw1[9:8];
    vid = aw1[10];
  end

  wire adv = out_ready;
  assign in_ready = out_ready;

  logic signed [PW-1:0] p1 [3][3];
  logic signed [OW-1:0] o1 [3];
  logic [1:0] s1;
  logic       sat1, v1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1 <= 1'b0; s1 <= '0; sat1 <= 1'b0;
      for (int i = 0; i < 3; i++) begin
        o1[i] <= '0;
        for (int j = 0; j < 3; j++) p1[i][j] <= '0;
      end
    end else if (adv) begin
      v1   <= in_valid;
      s1   <= scl;
      sat1 <= vid;
      for (int i = 0; i < 3; i++) begin
        o1[i] <= off[i];
        for (int j = 0; j < 3; j++)
          p1[i][j] <= k[i][j] * $signed({1'b0, in_pix[CW*j +: CW]});
      end
    end
  end

  logic signed [AW-1:0] acc [3];
  logic signed [AW-1:0] oe  [3];
  logic signed [AW-1:0] tot [3];

  always_comb begin
    for (int i = 0; i < 3; i++) begin
      acc[i] = p1[i][0] + p1[i][1] + p1[i][2];
      oe[i]  = o1[i];
      tot[i] = (acc[i] <<< s1) + (oe[i] <<< 7) + 26'sd256;
    end
  end

  logic signed [RW-1:0] r2 [3];
  logic sat2, v2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v2 <= 1'b0; sat2 <= 1'b0;
      for (int i = 0; i < 3; i++) r2[i] <= '0;
    end else if (adv) begin
      v2   <= v1;
      sat2 <= sat1;
      for (int i = 0; i < 3; i++) r2[i] <= RW'(tot[i] >>> 9);
    end
  end

  logic signed [RW-1:0] lo [3];
  logic signed [RW-1:0] hi [3];
  logic [CW-1:0] cl [3];

  always_comb begin
    for (int i = 0; i < 3; i++) begin
      lo[i] = sat2 ? RW'(16) : RW'(0);
      hi[i] = sat2 ? ((i == 0) ? RW'(235) : RW'(240)) : RW'(255);
      if (r2[i] < lo[i])      cl[i] = CW'(lo[i]);
      else if (r2[i] > hi[i]) cl[i] = CW'(hi[i]);
      else                    cl[i] = CW'(r2[i]);
    end
  end

  logic [CW-1:0] q3 [3];
  logic sat3, v3;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v3 <= 1'b0; sat3 <= 1'b0;
      for (int i = 0; i < 3; i++) q3[i] <= '0;
    end else if (adv) begin
      v3   <= v2;
      sat3 <= sat2;
      for (int i = 0; i < 3; i++) q3[i] <= cl[i];
    end
  end

  assign out_valid = v3;
  assign out_pix   = {q3[2], q3[1], q3[0]};

  p_hold_on_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pix)));

  p_advance_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (v2 && out_ready) |=> out_valid);

  p_luma_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && sat3) |-> (out_pix[7:0] >= 8'd16 && out_pix[7:0] <= 8'd235));

  p_chroma_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && sat3) |-> (out_pix[15:8] >= 8'd16 && out_pix[15:8] <= 8'd240 &&
                             out_pix[23:16] >= 8'd16 && out_pix[23:16] <= 8'd240));

  p_frozen_input_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_ready |=> $stable(v1));
endmodule

// File: tb/pix_matrix_conv_test.sv
module pix_matrix_conv_test;
  logic clk = 0;
  logic rst_n = 0;
  logic cfg_we = 0;
  logic [2:0] cfg_addr = 0;
  logic [31:0] cfg_wdata = 0;
  logic frame_start = 0;
  logic in_valid = 0;
  logic in_ready;
  logic [23:0] in_pix = 0;
  logic out_valid;
  logic out_ready = 1;
  logic [23:0] out_pix;

  always #4 clk = ~clk;

  pix_matrix_conv uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .frame_start(frame_start), .in_valid(in_valid),
    .in_ready(in_ready), .in_pix(in_pix), .out_valid(out_valid),
    .out_ready(out_ready), .out_pix(out_pix)
  );

  int n_chk = 0;
  int n_bad = 0;
  int bc [3][3];
  int bo [3];
  int bs;
  int bsat;
  logic [31:0] w [6];

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clear_cfg();
    for (int i = 0; i < 3; i++) begin
      bo[i] = 0;
      for (int j = 0; j < 3; j++) bc[i][j] = 0;
    end
    bs = 1; bsat = 0;
  endtask

  task automatic pack();
    logic [12:0] o [3];
    logic [8:0] c [3][3];
    for (int i = 0; i < 3; i++) begin
      o[i] = 13'(bo[i]);
      for (int j = 0; j < 3; j++) c[i][j] = 9'(bc[i][j]);
    end
    w[0] = {o[0][4:0], c[0][0], c[1][1], c[2][2]};
    w[1] = {21'd0, 1'(bsat), 2'(bs), o[0][12:5]};
    w[2] = {o[1][4:0], c[0][1], c[1][0], c[2][0]};
    w[3] = {24'd0, o[1][12:5]};
    w[4] = {o[2][4:0], c[0][2], c[1][2], c[2][1]};
    w[5] = {24'd0, o[2][12:5]};
  endtask

  task automatic write_words();
    pack();
    for (int a = 0; a < 6; a++) begin
      @(negedge clk);
      cfg_we = 1; cfg_addr = 3'(a); cfg_wdata = w[a];
    end
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic strobe();
    frame_start = 1;
    @(negedge clk);
    frame_start = 0;
  endtask

  task automatic load();
    write_words();
    strobe();
  endtask

  function automatic logic [23:0] model(logic [23:0] p);
    logic [23:0] r;
    real f;
    f = (bs == 0) ? 0.5 : (bs == 1) ? 1.0 : (bs == 2) ? 2.0 : 4.0;
    for (int i = 0; i < 3; i++) begin
      real acc;
      int v, lo, hi;
      acc = 0.0;
      for (int j = 0; j < 3; j++) acc = acc + real'(bc[i][j] * int'(p[8*j +: 8]));
      v = $rtoi($floor(acc * f / 256.0 + real'(bo[i]) / 4.0 + 0.5));
      lo = bsat ? 16 : 0;
      hi = bsat ? ((i == 0) ? 235 : 240) : 255;
      if (v < lo) v = lo;
      if (v > hi) v = hi;
      r[8*i +: 8] = 8'(v);
    end
    return r;
  endfunction

  task automatic send_one(string tag, logic [23:0] p, logic [23:0] exp);
    @(negedge clk);
    in_valid = 1; in_pix = p;
    @(negedge clk);
    in_valid = 0;
    @(negedge clk);
    check({tag, " early"}, 32'(out_valid), 32'd0);
    @(negedge clk);
    check({tag, " valid"}, 32'(out_valid), 32'd1);
    check(tag, 32'(out_pix), 32'(exp));
  endtask

  task automatic t_reset();
    check("R10 out_valid after reset", 32'(out_valid), 32'd0);
    check("R9 in_ready follows out_ready", 32'(in_ready), 32'd1);
    clear_cfg(); bs = 0;
    send_one("R10 zero params", 24'hA5C3FF, 24'h000000);
  endtask

  task automatic t_identity();
    clear_cfg(); bs = 2;
    bc[0][0] = 128; bc[1][1] = 128; bc[2][2] = 128;
    load();
    send_one("R1 identity a", 24'h123456, 24'h123456);
    send_one("R1 identity b", 24'hFF00A5, 24'hFF00A5);
  endtask

  task automatic t_swap();
    clear_cfg(); bs = 2;
    bc[0][1] = 128; bc[1][0] = 128; bc[2][2] = 128;
    load();
    send_one("R1 swap ch0/ch1", 24'h112233, 24'h113322);
    clear_cfg(); bs = 2;
    bc[0][2] = 128; bc[1][2] = 128; bc[2][1] = 128;
    load();
    send_one("R1 upper/lower fields", 24'h40_20_10, 24'h20_40_40);
    clear_cfg(); bs = 2;
    bc[2][0] = 128;
    load();
    send_one("R1 k20 field", 24'h000077, 24'h770000);
  endtask

  task automatic t_scale();
    logic [23:0] ex [4];
    ex[0] = 24'd25; ex[1] = 24'd50; ex[2] = 24'd100; ex[3] = 24'd200;
    for (int s = 0; s < 4; s++) begin
      clear_cfg(); bs = s; bc[0][0] = 64;
      load();
      send_one($sformatf("R4 scale code %0d", s), 24'h0000C8, ex[s]);
    end
  endtask

  task automatic t_round();
    clear_cfg(); bs = 1; bc[0][0] = 1;
    load();
    send_one("R3 round half up", 24'h000080, 24'h000001);
    send_one("R3 round below half", 24'h00007F, 24'h000000);
  endtask

  task automatic t_clamp();
    clear_cfg(); bs = 3;
    bc[0][0] = 255; bc[0][1] = 255; bc[0][2] = 255;
    bc[1][0] = -256;
    bo[2] = -4;
    load();
    send_one("R5 clamp high/low", 24'h808080, 24'h0000FF);
    clear_cfg(); bs = 1;
    bo[0] = 4 * 200; bo[1] = 4 * 17; bo[2] = 4 * 300;
    load();
    send_one("R2 offsets only", 24'h000000, 24'hFF11C8);
  endtask

  task automatic t_sat();
    clear_cfg(); bs = 1; bsat = 1;
    bo[0] = 0; bo[1] = 1000; bo[2] = -400;
    load();
    send_one("R6 low luma, high chroma", 24'h00FFFF, 24'h10F010);
    clear_cfg(); bs = 1; bsat = 1;
    bo[0] = 1000; bo[1] = 4 * 236; bo[2] = 4 * 241;
    load();
    send_one("R6 high luma, chroma edge", 24'h000000, 24'hF0ECEB);
    bsat = 0;
    load();
    send_one("R5 same offsets no video range", 24'h000000, 24'hF1ECFA);
  endtask

  task automatic t_general();
    clear_cfg(); bs = 1; bsat = 1;
    bc[0][0] = 77;  bc[0][1] = 150;  bc[0][2] = 29;
    bc[1][0] = -43; bc[1][1] = -85;  bc[1][2] = 128;
    bc[2][0] = 128; bc[2][1] = -107; bc[2][2] = -21;
    bo[0] = 0; bo[1] = 512; bo[2] = 512;
    load();
    send_one("R3 mixed sums a", 24'h3080E0, model(24'h3080E0));
    send_one("R3 mixed sums b", 24'hFFFFFF, model(24'hFFFFFF));
    send_one("R3 mixed sums c", 24'h10F020, model(24'h10F020));
  endtask

  task automatic t_shadow();
    clear_cfg(); bs = 2;
    bc[0][0] = 128; bc[1][1] = 128; bc[2][2] = 128;
    load();
    bc[0][0] = 0; bc[1][1] = 0; bc[0][1] = 128; bc[1][0] = 128;
    write_words();
    send_one("R7 staged not active", 24'h112233, 24'h112233);
    strobe();
    send_one("R7 active after strobe", 24'h112233, 24'h113322);
  endtask

  task automatic t_stream();
    logic [23:0] px [3];
    clear_cfg(); bs = 2;
    bc[0][0] = 128; bc[1][1] = 128; bc[2][2] = 128;
    load();
    px[0] = 24'h010203; px[1] = 24'hA0B0C0; px[2] = 24'h7F807F;
    for (int kk = 0; kk < 6; kk++) begin
      @(negedge clk);
      if (kk >= 3) begin
        check("R8 stream valid", 32'(out_valid), 32'd1);
        check("R8 stream order", 32'(out_pix), 32'(px[kk-3]));
      end
      if (kk < 3) begin
        in_valid = 1; in_pix = px[kk];
      end else in_valid = 0;
    end
    @(negedge clk);
    check("R8 stream drained", 32'(out_valid), 32'd0);
  endtask

  task automatic t_stall();
    @(negedge clk);
    in_valid = 1; in_pix = 24'h445566;
    @(negedge clk);
    in_valid = 0; out_ready = 0;
    repeat (5) @(negedge clk);
    check("R9 in_ready low on stall", 32'(in_ready), 32'd0);
    check("R9 no output while frozen", 32'(out_valid), 32'd0);
    out_ready = 1;
    @(negedge clk);
    check("R9 still in flight", 32'(out_valid), 32'd0);
    @(negedge clk);
    check("R9 resumed valid", 32'(out_valid), 32'd1);
    check("R9 resumed data", 32'(out_pix), 32'h445566);
    out_ready = 0;
    repeat (3) @(negedge clk);
    check("R9 held valid", 32'(out_valid), 32'd1);
    check("R9 held data", 32'(out_pix), 32'h445566);
    out_ready = 1;
    @(negedge clk);
    check("R9 released", 32'(out_valid), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_identity();
    t_swap();
    t_scale();
    t_round();
    t_clamp();
    t_sat();
    t_general();
    t_shadow();
    t_stream();
    t_stall();
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule